// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit performs the configuration step that comes before a run of vector work. Each request carries four items: an application vector length (the number of elements that software still has to process), a code for the element width, a code for the register-group multiplier, and two policy flags for tail and masked elements. A request may instead ask for the largest length the hardware can give. The unit checks that the requested type is legal for the fixed register width and the widest supported element. It then works out the maximum element count that one instruction can cover with those settings, and returns how many elements this pass will handle.

The granted length appears combinationally in the same cycle as the request. On a valid strobe, the unit also loads it into a vl register and loads a packed type value into a type register. Software loops subtract the granted length from the remaining count and repeat until nothing is left. When the remaining count lies between one and two full passes, the unit can split it evenly across the last two passes, or it can grant a full pass. A parameter selects which.

Top module: `vcfg_unit`

## Requirements
- R1: The maximum count is VMAX = MUL × VLEN / SEW. Width code c in 0..3 selects SEW = 8·2^c. Multiplier code 0,1,2,3 selects 1,2,4,8, and codes 5,6,7 select 1/8, 1/4, 1/2.
- R2: For a legal type without the maximum-length flag, a requested length that is at most VMAX is granted unchanged. A request of 0 grants 0.
- R3: For a legal type without the maximum-length flag, a requested length of at least 2·VMAX is granted VMAX.
- R4: For a legal type where the request lies strictly between VMAX and 2·VMAX, the grant is ceil(AVL/2) when BALANCE is 1 and VMAX when BALANCE is 0.
- R5: When the maximum-length flag is set with a legal type, the grant is VMAX and the requested length is ignored.
- R6: A width code of 4 or more, or a SEW greater than ELEN, makes the type illegal, and the grant is 0.
- R7: Multiplier code 4 is illegal. A fractional multiplier with MUL × VLEN < SEW is also illegal. The grant is 0 in both cases.
- R8: After an illegal request is captured, type_q has bit 8 set, all its other bits at 0, and vl_q at 0.
- R9: vl_q and type_q load the grant and the type in the cycle after a clock edge where req_valid is high, and they hold when req_valid is low. A legal type packs as bit 8 = 0, bit 7 = mask-agnostic, bit 6 = tail-agnostic, bits 5:3 = width code, bits 2:0 = multiplier code.
- R10: A synchronous active-high reset clears vl_q and type_q to 0.
- R11: grant_vl reflects the current inputs combinationally, whether or not req_valid is high.
- R12: VLEN must be a power of two no larger than 65536, and ELEN must be a power of two with 8 ≤ ELEN ≤ min(VLEN, 64). With the width code at 0 and the multiplier code at 3, the grant reaches VLEN and fits in the vl width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Strobe that loads the vl and type registers |
| req_avl | input | AVL_W | Requested application vector length |
| req_sew_code | input | 3 | Element-width code |
| req_lmul_code | input | 3 | Register-group multiplier code |
| req_tail_agn | input | 1 | Tail-agnostic policy flag |
| req_mask_agn | input | 1 | Mask-agnostic policy flag |
| req_use_max | input | 1 | Request the maximum length and ignore req_avl |
| grant_vl | output | log2(VLEN)+1 | Combinational granted length |
| vl_q | output | log2(VLEN)+1 | Registered vector length |
| type_q | output | 9 | Registered type value with the illegal bit at bit 8 |

## Verification
The properties assume that all request inputs hold known values after reset and stay stable between clock edges. The capture and hold checks also assume that reset itself is the only other event that moves the registers. The bench changes its inputs only shortly after the falling edge and never leaves them undriven. The random phase draws every 3-bit code, including the reserved ones, so the illegal paths are reached under the same timing rules as the legal ones. Two instances with different widths and balance settings run on the same stimulus, so each rule is seen in both configurations.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    // Packed type register layout: illegal | mask-agn | tail-agn | sew | lmul
    typedef struct packed {
        logic       illegal;
        logic       mask_agn;
        logic       tail_agn;
        logic [2:0] sew;
        logic [2:0] lmul;
    } vtype_t;

    typedef enum logic [2:0] {
        LMUL_X1  = 3'd0,
        LMUL_X2  = 3'd1,
        LMUL_X4  = 3'd2,
        LMUL_X8  = 3'd3,
        LMUL_RSV = 3'd4,
        LMUL_F8  = 3'd5,
        LMUL_F4  = 3'd6,
        LMUL_F2  = 3'd7
    } lmul_code_e;

    localparam logic [2:0] SEW_CODE_MAX = 3'd3;

    // log2 of the element width in bits
    function automatic logic signed [7:0] sew_exp(input logic [2:0] code);
        return 8'sd3 + $signed({5'b00000, code});
    endfunction

    // log2 of the group multiplier: codes 5..7 map to -3..-1
    function automatic logic signed [7:0] lmul_exp(input logic [2:0] code);
        return code[2] ? $signed({5'b11111, code}) : $signed({5'b00000, code});
    endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int ELEN = 64,
    parameter int VL_W = 8
) (
    input  logic [2:0]      sew_code,
    input  logic [2:0]      lmul_code,
    output logic            legal,
    output logic [VL_W-1:0] vlmax
);
    localparam logic signed [7:0] LOG_VLEN = 8'($clog2(VLEN));
    localparam logic signed [7:0] LOG_ELEN = 8'($clog2(ELEN));

    logic signed [7:0] s_exp;
    logic signed [7:0] l_exp;
    logic signed [7:0] log_vm;

    always_comb begin
        s_exp  = sew_exp(sew_code);
        l_exp  = lmul_exp(lmul_code);
        log_vm = LOG_VLEN + l_exp - s_exp;
        legal  = (sew_code <= SEW_CODE_MAX)
              && (s_exp <= LOG_ELEN)
              && (lmul_code != LMUL_RSV)
              && (log_vm >= 8'sd0);
        vlmax  = legal ? (VL_W'(1) << log_vm[4:0]) : '0;
    end
endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
    parameter int AVL_W   = 32,
    parameter int VL_W    = 8,
    parameter bit BALANCE = 1'b1
) (
    input  logic [AVL_W-1:0] avl,
    input  logic             use_max,
    input  logic             legal,
    input  logic [VL_W-1:0]  vlmax,
    output logic [VL_W-1:0]  vl
);
    localparam int CW = AVL_W + 2;

    logic [CW-1:0] avl_x;
    logic [CW-1:0] vm_x;
    logic [CW-1:0] mid_x;
    logic [CW-1:0] pick;

    assign avl_x = CW'(avl);
    assign vm_x  = CW'(vlmax);

    // Grant for the region between one and two full passes
    generate
        if (BALANCE) begin : g_balance
            assign mid_x = (avl_x + CW'(1)) >> 1;
        end else begin : g_full
            assign mid_x = vm_x;
        end
    endgenerate

    always_comb begin
        if (!legal)                    pick = '0;
        else if (use_max)              pick = vm_x;
        else if (avl_x <= vm_x)        pick = avl_x;
        else if (avl_x >= (vm_x << 1)) pick = vm_x;
        else                           pick = mid_x;
        vl = VL_W'(pick);
    end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN    = 128,
    parameter int ELEN    = 64,
    parameter int AVL_W   = 32,
    parameter bit BALANCE = 1'b1,
    localparam int VL_W   = $clog2(VLEN) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [AVL_W-1:0] req_avl,
    input  logic [2:0]       req_sew_code,
    input  logic [2:0]       req_lmul_code,
    input  logic             req_tail_agn,
    input  logic             req_mask_agn,
    input  logic             req_use_max,
    output logic [VL_W-1:0]  grant_vl,
    output logic [VL_W-1:0]  vl_q,
    output logic [8:0]       type_q
);
    logic            dec_legal;
    logic [VL_W-1:0] dec_vlmax;
    vtype_t          type_nxt;
    vtype_t          type_r;

    vcfg_decode #(.VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_decode (
        .sew_code  (req_sew_code),
        .lmul_code (req_lmul_code),
        .legal     (dec_legal),
        .vlmax     (dec_vlmax)
    );

    vcfg_grant #(.AVL_W(AVL_W), .VL_W(VL_W), .BALANCE(BALANCE)) u_grant (
        .avl     (req_avl),
        .use_max (req_use_max),
        .legal   (dec_legal),
        .vlmax   (dec_vlmax),
        .vl      (grant_vl)
    );

    always_comb begin
        type_nxt = '0;
        if (dec_legal) begin
            type_nxt.mask_agn = req_mask_agn;
            type_nxt.tail_agn = req_tail_agn;
            type_nxt.sew      = req_sew_code;
            type_nxt.lmul     = req_lmul_code;
        end else begin
            type_nxt.illegal  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q   <= '0;
            type_r <= '0;
        end else if (req_valid) begin
            vl_q   <= grant_vl;
            type_r <= type_nxt;
        end
    end

    assign type_q = type_r;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int AVL_W = 32,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [AVL_W-1:0] req_avl,
    input logic             req_use_max,
    input logic             legal,
    input logic [VL_W-1:0]  grant_vl,
    input logic [VL_W-1:0]  vl_q,
    input logic [8:0]       type_q
);
    logic rst_d;

    initial begin
        AST_VLEN_SHAPE: assert (((VLEN & (VLEN - 1)) == 0) && VLEN <= 65536); // R12
        AST_ELEN_SHAPE: assert (((ELEN & (ELEN - 1)) == 0) && ELEN >= 8 && ELEN <= 64 && ELEN <= VLEN); // R12
    end

    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_CLEAR: assert (vl_q == '0 && type_q == '0); // R10
        end
    end

    AST_ILLEGAL_VL_ZERO: assert property (@(posedge clk) disable iff (rst)
        type_q[8] |-> vl_q == '0); // R8
    AST_ILLEGAL_FIELDS: assert property (@(posedge clk) disable iff (rst)
        type_q[8] |-> type_q[7:0] == 8'd0); // R8
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> vl_q == $past(grant_vl)); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(vl_q) && $stable(type_q)); // R9
    AST_NOT_ABOVE_AVL: assert property (@(posedge clk) disable iff (rst)
        (legal && !req_use_max) |-> AVL_W'(grant_vl) <= req_avl); // R2
    AST_MAX_POW2: assert property (@(posedge clk) disable iff (rst)
        (legal && req_use_max) |-> $countones(grant_vl) == 1); // R5
    AST_ILLEGAL_GRANT: assert property (@(posedge clk) disable iff (rst)
        !legal |-> grant_vl == '0); // R6
endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN), .ELEN(ELEN), .AVL_W(AVL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_avl     (req_avl),
    .req_use_max (req_use_max),
    .legal       (dec_legal),
    .grant_vl    (grant_vl),
    .vl_q        (vl_q),
    .type_q      (type_q)
);

// File: tb/tb_vcfg_unit.sv
module tb_vcfg_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_avl = '0;
    logic [2:0]  req_sew_code = '0;
    logic [2:0]  req_lmul_code = '0;
    logic        req_tail_agn = 1'b0;
    logic        req_mask_agn = 1'b0;
    logic        req_use_max = 1'b0;

    logic [7:0] g_a, vq_a;
    logic [8:0] tq_a;
    logic [6:0] g_b, vq_b;
    logic [8:0] tq_b;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    vcfg_unit #(.VLEN(128), .ELEN(64), .AVL_W(32), .BALANCE(1'b1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_avl(req_avl),
        .req_sew_code(req_sew_code), .req_lmul_code(req_lmul_code),
        .req_tail_agn(req_tail_agn), .req_mask_agn(req_mask_agn),
        .req_use_max(req_use_max), .grant_vl(g_a), .vl_q(vq_a), .type_q(tq_a)
    );

    vcfg_unit #(.VLEN(64), .ELEN(32), .AVL_W(32), .BALANCE(1'b0)) dut_b (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_avl(req_avl),
        .req_sew_code(req_sew_code), .req_lmul_code(req_lmul_code),
        .req_tail_agn(req_tail_agn), .req_mask_agn(req_mask_agn),
        .req_use_max(req_use_max), .grant_vl(g_b), .vl_q(vq_b), .type_q(tq_b)
    );

    // Behavioural reference for one request
    function automatic void ref_calc(input int vlen, input int elen, input bit bal,
                                     input longint avl, input int sc, input int lc,
                                     input bit um, input bit ta, input bit ma,
                                     output longint vl, output int typ, output string tag);
        int     sew;
        int     base;
        longint vm;
        bit     bad_w;
        bit     bad_m;
        sew = 8 << (sc & 3);
        vm = 0;
        bad_w = (sc > 3) || (sew > elen);
        bad_m = (lc == 4);
        if (!bad_w && !bad_m) begin
            if (lc < 4) vm = longint'(vlen * (1 << lc)) / sew;
            else begin
                base = vlen >> (8 - lc);
                if (base < sew) bad_m = 1'b1;
                else vm = longint'(base / sew);
            end
        end
        if (bad_w || bad_m) begin
            vl = 0; typ = 256; tag = bad_w ? "R6" : "R7";
        end else begin
            typ = (int'(ma) << 7) | (int'(ta) << 6) | (sc << 3) | lc;
            if (um)                  begin vl = vm;  tag = "R5"; end
            else if (avl <= vm)      begin vl = avl; tag = "R2"; end
            else if (avl >= 2 * vm)  begin vl = vm;  tag = "R3"; end
            else begin vl = bal ? (avl + 1) / 2 : vm; tag = "R4"; end
        end
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Model registers
    longint e_vl_a = 0, e_vl_b = 0;
    int     e_ty_a = 0, e_ty_b = 0;
    string  rtag_a = "R10", rtag_b = "R10";

    always @(posedge clk) begin
        longint v; int t; string s;
        if (rst) begin
            e_vl_a = 0; e_ty_a = 0; rtag_a = "R10";
            e_vl_b = 0; e_ty_b = 0; rtag_b = "R10";
        end else if (req_valid) begin
            ref_calc(128, 64, 1'b1, longint'(req_avl), int'(req_sew_code), int'(req_lmul_code),
                     req_use_max, req_tail_agn, req_mask_agn, v, t, s);
            e_vl_a = v; e_ty_a = t; rtag_a = (t == 256) ? "R8" : "R9";
            ref_calc(64, 32, 1'b0, longint'(req_avl), int'(req_sew_code), int'(req_lmul_code),
                     req_use_max, req_tail_agn, req_mask_agn, v, t, s);
            e_vl_b = v; e_ty_b = t; rtag_b = (t == 256) ? "R8" : "R9";
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        longint v; int t; string s;
        if (!done) begin
            ref_calc(128, 64, 1'b1, longint'(req_avl), int'(req_sew_code), int'(req_lmul_code),
                     req_use_max, req_tail_agn, req_mask_agn, v, t, s);
            chk({"R11 ", s}, "grant_a", longint'(g_a), v);
            ref_calc(64, 32, 1'b0, longint'(req_avl), int'(req_sew_code), int'(req_lmul_code),
                     req_use_max, req_tail_agn, req_mask_agn, v, t, s);
            chk({"R11 ", s}, "grant_b", longint'(g_b), v);
            chk(rtag_a, "vl_q_a", longint'(vq_a), e_vl_a);
            chk(rtag_a, "type_q_a", longint'(tq_a), longint'(e_ty_a));
            chk(rtag_b, "vl_q_b", longint'(vq_b), e_vl_b);
            chk(rtag_b, "type_q_b", longint'(tq_b), longint'(e_ty_b));
        end
    end

    task automatic drive(input bit v, input logic [31:0] avl, input int sc, input int lc,
                         input bit um, input bit ta, input bit ma);
        @(negedge clk);
        #2;
        req_valid = v; req_avl = avl; req_sew_code = 3'(sc); req_lmul_code = 3'(lc);
        req_use_max = um; req_tail_agn = ta; req_mask_agn = ma;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state, inputs busy during reset
        rst = 1'b1;
        drive(1, 32'd5, 2, 0, 0, 1, 1);
        drive(1, 32'd9, 0, 3, 1, 0, 1);
        drive(0, 32'd0, 0, 0, 0, 0, 0);
        rst = 1'b0;

        // R1, R5, R6, R7: every code pair with max flag and with a fixed AVL
        for (int sc = 0; sc < 8; sc++)
            for (int lc = 0; lc < 8; lc++) begin
                drive(1, 32'd13, sc, lc, 1, sc[0], lc[0]);
                drive(1, 32'd13, sc, lc, 0, lc[1], sc[1]);
            end

        // R2, R3, R4: boundaries around VMAX (4 for dut, 2 for dut_b at e32/m1)
        foreach (req_avl[i]) begin end
        for (int k = 0; k < 10; k++) drive(1, 32'(k), 2, 0, 0, 0, 0);
        drive(1, 32'd1000, 2, 0, 0, 1, 0);
        drive(1, 32'hFFFF_FFFF, 2, 0, 0, 0, 1);
        for (int k = 120; k < 260; k += 7) drive(1, 32'(k), 0, 3, 0, 1, 1);

        // R12: widest group at byte width reaches VLEN
        drive(1, 32'd0, 0, 3, 1, 0, 0);
        #1 chk("R12", "grant_a at e8/m8", longint'(g_a), 128);

        // R9: hold while strobe is low and inputs move
        for (int k = 0; k < 6; k++) drive(0, 32'(k * 3), k % 4, k % 3, k[0], 1, 0);
        // R8 then hold of an illegal capture
        drive(1, 32'd7, 5, 0, 0, 1, 1);
        drive(0, 32'd7, 0, 0, 0, 0, 0);
        drive(0, 32'd3, 1, 1, 0, 1, 1);

        // R10: reset in mid-run
        rst = 1'b1;
        drive(1, 32'd4, 1, 1, 0, 0, 0);
        rst = 1'b0;
        drive(0, 32'd4, 1, 1, 0, 0, 0);

        // Random phase over all codes, both policies and strobe patterns
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a;
            a = ($urandom_range(0, 7) == 0) ? 32'($urandom) : 32'($urandom_range(0, 300));
            drive($urandom_range(0, 3) != 0, a, int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 7)), $urandom_range(0, 5) == 0,
                  1'($urandom), 1'($urandom));
        end

        drive(0, 32'd0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule